// File: doc/BRIEF.md
# Addressable Register Board

This block is one board of a bus-attached register file. It holds four 16-bit registers that all share one bidirectional data bus. Identical boards can hang on the same bus because each board is given a 3-bit identifier by static strapping. A 5-bit address names each register: the top three bits pick the board and the bottom two bits pick the register on it. There are two such addresses, one for the load path and one for the drive path, and each has its own global strobe. One bus therefore serves up to 32 registers.

Each path has its own decoder. The decoder takes the XOR of the address's board field with the strapped identifier, requires that every difference bit is zero, and gates the result with its strobe. The low address bits then expand to a one-hot register select. A selected load target samples the bus on the rising clock edge. A selected drive target puts its contents on the bus through per-bit tristate drivers. When no register is selected, every bus bit is left at high impedance.

Each register has its own small clock controller. The controller turns the load select and the board reset into a capture enable and the complementary hold phase. Its state register has three states:
- CS_CLEAR: entered asynchronously while reset is asserted.
- CS_WAIT: reached on the first rising edge after reset is released, and on any edge without a load select.
- CS_WRITE: reached on any edge with a load select, provided the controller was not in CS_CLEAR.

The incoming global reset is active high. The board inverts it to get the active-low reset used by its registers.

Top module: `regboard_top`

## Requirements
- R1: A register whose load select is active samples `data_bus` on the rising `clk` edge, and keeps that value until it is loaded again or reset.
- R2: The board responds only when address bits [4:2] equal `board_id`. Address bits [1:0] then choose register 0 to 3, so board n serves addresses 4n to 4n+3.
- R3: A load or drive address whose bits [4:2] differ from `board_id` loads no register, drives no bus bit, and leaves all four registers unchanged.
- R4: While `load_strobe` is low no register loads, and while `out_strobe` is low no register drives, whatever the addresses (including 00000).
- R5: While a register is the selected drive target, its value appears on `data_bus` in the same cycle. Otherwise the board leaves every bus bit undriven, so another source on the bus keeps its value.
- R6: Load and drive are decoded independently. In one cycle the board can drive one register and load another, including across boards, which gives a register-to-register copy in one edge.
- R7: If one register is both the load target and the drive target, the bus carries its pre-edge value and the register still holds that value after the edge.
- R8: While `sys_reset` is high (active high), all four registers are zero immediately. This holds even if a load is requested.
- R9: `loading_led` and `driving_led` give the current one-hot load and drive selects, with bit i standing for register i. Each is all zeros when its path is idle.
- R10: `id_led` always equals `board_id`.
- R11: Neither status vector ever has more than one bit set, so at most one register on a board drives at a time.
- R12: The first rising edge after `sys_reset` falls never loads a register. Loads take effect from the second edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; registers sample on its rising edge |
| sys_reset | input | 1 | Global reset, active high, asynchronous |
| board_id | input | 3 | Strapped board identifier |
| load_strobe | input | 1 | Global enable for the load path |
| load_addr | input | 5 | Address of the register to load |
| out_strobe | input | 1 | Global enable for the drive path |
| out_addr | input | 5 | Address of the register to drive |
| data_bus | inout | 16 | Shared data bus with per-bit tristate drive |
| loading_led | output | 4 | One-hot current load select |
| driving_led | output | 4 | One-hot current drive select |
| id_led | output | 3 | Copy of the board identifier |

## Verification
The faults that matter most are a decoder that matches the wrong board, or one that ignores its strobe. Either shows up at once on the status vectors. It also shows up on the bus in the same cycle, as a value from the wrong register or as two boards driving at the same time. A register that captures when it should not is only visible on the next read of that register. For that reason every write and every ignored stimulus is followed by reading back all affected addresses. A clock controller that is stuck in, or skips, its post-reset state shows up one edge after reset release: a load that should have been suppressed is kept, or a later load is lost.

// File: rtl/regboard_pkg.sv
`timescale 1ns/1ps
package regboard_pkg;

    // Per-register clock controller states.
    typedef enum logic [1:0] {
        CS_CLEAR = 2'd0,   // held in reset, or first edge after release not yet seen
        CS_WAIT  = 2'd1,   // armed, last edge did not capture
        CS_WRITE = 2'd2    // last edge captured the bus
    } clk_state_e;

endpackage

// File: rtl/regboard_decode.sv
`timescale 1ns/1ps
// Board-identifier match plus local one-hot select for one access path.
module regboard_decode #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned ID_W   = 3,
    localparam int unsigned LOC_W = ADDR_W - ID_W,
    localparam int unsigned NSEL  = 1 << LOC_W
) (
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   board_id,
    output logic [NSEL-1:0]   sel
);
    logic [ID_W-1:0] id_diff;
    logic            id_match;
    logic            hit;

    assign id_diff  = addr[ADDR_W-1 -: ID_W] ^ board_id;
    assign id_match = ~|id_diff;
    assign hit      = strobe & id_match;

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign sel[i] = hit && (addr[LOC_W-1:0] == LOC_W'(i));
    end

    // R4: an idle strobe selects nothing
    always_comb begin
        if (!strobe) begin
            p_strobe_gate_r4: assert (sel == '0);
        end
    end

    // R11: at most one local register selected
    always_comb begin
        p_sel_onehot_r11: assert ($onehot0(sel));
    end

endmodule

// File: rtl/regboard_clkctl.sv
`timescale 1ns/1ps
// Register clock controller: turns load select and reset into capture/hold phases.
module regboard_clkctl
    import regboard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_sel,
    output logic cap_en,
    output logic hold_en
);
    clk_state_e st_q;
    clk_state_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CS_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_CLEAR: st_d = CS_WAIT;
            CS_WAIT:  st_d = load_sel ? CS_WRITE : CS_WAIT;
            CS_WRITE: st_d = load_sel ? CS_WRITE : CS_WAIT;
            default:  st_d = CS_CLEAR;
        endcase
    end

    // Outputs: capture phase and its complement
    always_comb begin
        cap_en = 1'b0;
        unique case (st_q)
            CS_CLEAR: cap_en = 1'b0;
            CS_WAIT:  cap_en = load_sel & rst_n;
            CS_WRITE: cap_en = load_sel & rst_n;
            default:  cap_en = 1'b0;
        endcase
        hold_en = ~cap_en;
    end

    // R12: the first edge after reset release only leaves CS_CLEAR
    p_recover_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_CLEAR) |=> (st_q == CS_WAIT));

    // R1: a load request while armed lands in CS_WRITE
    p_arm_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_sel && st_q != CS_CLEAR) |=> (st_q == CS_WRITE));

endmodule

// File: rtl/regboard_cell.sv
`timescale 1ns/1ps
// One storage register, cleared by active-low reset.
module regboard_cell #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              hold_en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap_en) begin
            q <= d;
        end
    end

    // R1: capture takes the bus value present at the edge
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (q == $past(d)));

    // R3: hold phase leaves contents untouched
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_en |=> $stable(q));

endmodule

// File: rtl/regboard_top.sv
`timescale 1ns/1ps
// Board of four bus registers with independent load and drive decoders.
module regboard_top #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned ID_W   = 3,
    localparam int unsigned LOC_W = ADDR_W - ID_W,
    localparam int unsigned NREG  = 1 << LOC_W
) (
    input  logic              clk,
    input  logic              sys_reset,
    input  logic [ID_W-1:0]   board_id,
    input  logic              load_strobe,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              out_strobe,
    input  logic [ADDR_W-1:0] out_addr,
    inout  wire  [DATA_W-1:0] data_bus,
    output logic [NREG-1:0]   loading_led,
    output logic [NREG-1:0]   driving_led,
    output logic [ID_W-1:0]   id_led
);
    logic              reg_rst_n;
    logic [NREG-1:0]   load_sel;
    logic [NREG-1:0]   out_sel;
    logic [NREG-1:0]   cap_en;
    logic [NREG-1:0]   hold_en;
    logic [DATA_W-1:0] reg_q [NREG];
    logic [DATA_W-1:0] rd_val;
    logic              any_drive;

    // Board-level reset inversion
    assign reg_rst_n = ~sys_reset;

    regboard_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_load_dec (
        .strobe   (load_strobe),
        .addr     (load_addr),
        .board_id (board_id),
        .sel      (load_sel)
    );

    regboard_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_out_dec (
        .strobe   (out_strobe),
        .addr     (out_addr),
        .board_id (board_id),
        .sel      (out_sel)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        regboard_clkctl u_ctl (
            .clk      (clk),
            .rst_n    (reg_rst_n),
            .load_sel (load_sel[r]),
            .cap_en   (cap_en[r]),
            .hold_en  (hold_en[r])
        );

        regboard_cell #(.DATA_W(DATA_W)) u_cell (
            .clk     (clk),
            .rst_n   (reg_rst_n),
            .cap_en  (cap_en[r]),
            .hold_en (hold_en[r]),
            .d       (data_bus),
            .q       (reg_q[r])
        );

        // R5: the selected drive target is what the bus carries
        p_drive_value_r5: assert property (@(posedge clk) disable iff (!reg_rst_n)
            out_sel[r] |-> (data_bus == reg_q[r]));
    end

    // Read selection from the one-hot drive select
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NREG; i++) begin
            if (out_sel[i]) begin
                rd_val = rd_val | reg_q[i];
            end
        end
    end

    assign any_drive = |out_sel;

    // Per-bit tristate output
    for (genvar b = 0; b < DATA_W; b++) begin : g_bus
        assign data_bus[b] = any_drive ? rd_val[b] : 1'bz;
    end

    assign loading_led = load_sel;
    assign driving_led = out_sel;
    assign id_led      = board_id;

    // R4: no status activity while the strobes are low
    p_quiet_load_r4: assert property (@(posedge clk) disable iff (!reg_rst_n)
        !load_strobe |-> (loading_led == '0));
    p_quiet_out_r4: assert property (@(posedge clk) disable iff (!reg_rst_n)
        !out_strobe |-> (driving_led == '0));

    // R11: status vectors stay one-hot or empty
    p_led_onehot_r11: assert property (@(posedge clk) disable iff (!reg_rst_n)
        $onehot0(loading_led) && $onehot0(driving_led));

    // R10: identifier mirror follows the strapping
    p_id_mirror_r10: assert property (@(posedge clk) disable iff (!reg_rst_n)
        id_led == board_id);

endmodule

// File: tb/regboard_top_bench.sv
`timescale 1ns/1ps
module regboard_top_bench;

    logic        clk = 1'b0;
    logic        sys_reset = 1'b1;
    logic        ld_stb = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic        out_stb = 1'b0;
    logic [4:0]  out_addr = '0;
    logic        tb_en = 1'b0;
    logic [15:0] tb_val = '0;
    tri   [15:0] bus;

    logic [3:0] ld_led0, ld_led3, ld_led7;
    logic [3:0] dr_led0, dr_led3, dr_led7;
    logic [2:0] id0, id3, id7;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model [32];

    always #4 clk = ~clk;   // 125 MHz

    assign bus = tb_en ? tb_val : 16'hzzzz;

    regboard_top u_regboard_top (
        .clk(clk), .sys_reset(sys_reset), .board_id(3'd0),
        .load_strobe(ld_stb), .load_addr(ld_addr),
        .out_strobe(out_stb), .out_addr(out_addr), .data_bus(bus),
        .loading_led(ld_led0), .driving_led(dr_led0), .id_led(id0)
    );
    regboard_top u_regboard_top_b3 (
        .clk(clk), .sys_reset(sys_reset), .board_id(3'd3),
        .load_strobe(ld_stb), .load_addr(ld_addr),
        .out_strobe(out_stb), .out_addr(out_addr), .data_bus(bus),
        .loading_led(ld_led3), .driving_led(dr_led3), .id_led(id3)
    );
    regboard_top u_regboard_top_b7 (
        .clk(clk), .sys_reset(sys_reset), .board_id(3'd7),
        .load_strobe(ld_stb), .load_addr(ld_addr),
        .out_strobe(out_stb), .out_addr(out_addr), .data_bus(bus),
        .loading_led(ld_led7), .driving_led(dr_led7), .id_led(id7)
    );

    function automatic int n_drivers();
        return $countones(dr_led0) + $countones(dr_led3) + $countones(dr_led7);
    endfunction

    function automatic logic [3:0] ld_of(int b);
        return (b == 0) ? ld_led0 : (b == 3) ? ld_led3 : ld_led7;
    endfunction

    function automatic logic [3:0] dr_of(int b);
        return (b == 0) ? dr_led0 : (b == 3) ? dr_led3 : dr_led7;
    endfunction

    function automatic bit served(logic [4:0] a);
        return (a[4:2] == 3'd0) || (a[4:2] == 3'd3) || (a[4:2] == 3'd7);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [4:0] a, logic [15:0] v);
        @(negedge clk);
        tb_en = 1'b1; tb_val = v; ld_stb = 1'b1; ld_addr = a;
        #1;
        // R9: target board shows one-hot load select; others idle
        check(ld_of(a[4:2]) == (4'b0001 << a[1:0]), "R9 load status",
              32'(ld_of(a[4:2])), 32'(4'b0001 << a[1:0]));
        @(negedge clk);
        ld_stb = 1'b0; tb_en = 1'b0;
        model[a] = v;
    endtask

    task automatic do_read(logic [4:0] a, string req);
        @(negedge clk);
        out_stb = 1'b1; out_addr = a;
        #2;
        check(bus == model[a], req, 32'(bus), 32'(model[a]));
        check(n_drivers() == 1, "R11 single driver", n_drivers(), 1);
        out_stb = 1'b0;
    endtask

    task automatic read_all(string req);
        for (int a = 0; a < 32; a++) begin
            if (served(5'(a))) do_read(5'(a), req);
        end
    endtask

    task automatic t_reset();
        for (int a = 0; a < 32; a++) model[a] = '0;
        sys_reset = 1'b1;
        repeat (3) @(negedge clk);
        // R8: contents are zero while reset is held
        do_read(5'd0, "R8 reset clear");
        do_read(5'd31, "R8 reset clear");
        check(id0 == 3'd0 && id3 == 3'd3 && id7 == 3'd7, "R10 id mirror",
              32'({id0, id3, id7}), 32'({3'd0, 3'd3, 3'd7}));
        check(ld_led0 == 0 && dr_led3 == 0, "R9 idle status",
              32'({ld_led0, dr_led3}), 0);
        @(negedge clk);
        sys_reset = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_write_read();
        for (int a = 0; a < 32; a++) begin
            if (served(5'(a))) do_write(5'(a), 16'h1000 + 16'(a * 16'h0111));
        end
        // R1 R2: every served address reads back its own value
        read_all("R2 write/read back");
    endtask

    task automatic t_strobe_low();
        @(negedge clk);
        tb_en = 1'b1; tb_val = 16'hFFFF; ld_stb = 1'b0; ld_addr = 5'd0;
        #1;
        check(ld_led0 == 0, "R4 load strobe low", 32'(ld_led0), 0);
        @(negedge clk);
        tb_val = 16'h5A5A; out_stb = 1'b0; out_addr = 5'd0;
        #1;
        check(n_drivers() == 0, "R4 out strobe low", n_drivers(), 0);
        check(bus == 16'h5A5A, "R5 bus released", 32'(bus), 32'h5A5A);
        @(negedge clk);
        tb_en = 1'b0;
        do_read(5'd0, "R4 no load with strobe low");
    endtask

    task automatic t_unmapped();
        @(negedge clk);
        tb_en = 1'b1; tb_val = 16'hDEAD; ld_stb = 1'b1; ld_addr = 5'b01001;
        #1;
        check((ld_led0 | ld_led3 | ld_led7) == 0, "R3 foreign load address",
              32'(ld_led0 | ld_led3 | ld_led7), 0);
        @(negedge clk);
        ld_stb = 1'b0;
        tb_val = 16'hA5A5; out_stb = 1'b1; out_addr = 5'b10110;
        #1;
        check(n_drivers() == 0, "R3 foreign drive address", n_drivers(), 0);
        check(bus == 16'hA5A5, "R3 bus untouched", 32'(bus), 32'hA5A5);
        @(negedge clk);
        out_stb = 1'b0; tb_en = 1'b0;
        read_all("R3 registers unchanged");
    endtask

    task automatic t_transfer();
        @(negedge clk);
        out_stb = 1'b1; out_addr = 5'd1;
        ld_stb = 1'b1; ld_addr = 5'd30;
        #1;
        check(bus == model[1], "R6 source on bus", 32'(bus), 32'(model[1]));
        check(dr_led0 == 4'b0010 && ld_led7 == 4'b0100, "R6 split selects",
              32'({dr_led0, ld_led7}), 32'({4'b0010, 4'b0100}));
        @(negedge clk);
        out_stb = 1'b0; ld_stb = 1'b0;
        model[30] = model[1];
        do_read(5'd30, "R6 copy landed");
        do_read(5'd1, "R6 source kept");
    endtask

    task automatic t_self();
        @(negedge clk);
        out_stb = 1'b1; out_addr = 5'd13;
        ld_stb = 1'b1; ld_addr = 5'd13;
        #1;
        check(bus == model[13], "R7 pre-edge value", 32'(bus), 32'(model[13]));
        @(posedge clk);
        #1;
        check(bus == model[13], "R7 value after edge", 32'(bus), 32'(model[13]));
        @(negedge clk);
        out_stb = 1'b0; ld_stb = 1'b0;
        do_read(5'd13, "R7 register unchanged");
    endtask

    task automatic t_reset_priority();
        @(negedge clk);
        tb_en = 1'b1; tb_val = 16'hBEEF; ld_stb = 1'b1; ld_addr = 5'd12;
        sys_reset = 1'b1;
        for (int a = 0; a < 32; a++) model[a] = '0;
        @(negedge clk);
        ld_stb = 1'b0; tb_en = 1'b0;
        do_read(5'd12, "R8 reset beats load");
        do_read(5'd2, "R8 all boards cleared");
        // Release reset with a load already requested
        @(negedge clk);
        sys_reset = 1'b0;
        tb_en = 1'b1; tb_val = 16'h1234; ld_stb = 1'b1; ld_addr = 5'd12;
        @(negedge clk);
        ld_stb = 1'b0; tb_en = 1'b0;
        do_read(5'd12, "R12 first edge after reset ignored");
        do_write(5'd12, 16'h4321);
        do_read(5'd12, "R12 later edge loads");
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_strobe_low();
        t_unmapped();
        t_transfer();
        t_self();
        t_reset_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule